// File: doc/BRIEF.md
# Byte-Wide Oscillator Tuning Write Port

This block is the write side of a tuning oscillator. An 8-bit data bus, a 4-bit address bus, a write strobe and an active-low chip select load four buffer registers: two 32-bit frequency-increment buffers (A and B) and two 12-bit phase offsets, one for the sine channel and one for the cosine channel. The frequency buffers are filled a byte at a time, in any order. The phase offsets are filled as a high byte plus a low nibble.

The write strobe is asynchronous to the system clock. It is brought into the clock domain through a two-flop synchroniser, and one write is made for each rising edge it detects. A frequency-load request copies buffer A or buffer B to the registered frequency output. The frequency select input decides which buffer is used.

The phase outputs are registered every cycle. The phase-source select input picks what drives them. When it is high, each channel takes its own buffered register. When it is low, both channels take a raw 12-bit word from the pins: the address bus supplies the low four bits and the data bus supplies the upper eight. In that mode the strobe and the chip select play no part in the phase outputs.

Top module: `nco_wr_port`

## Requirements
- R1: While `rst_n` is low, every buffer and output is cleared to zero, asynchronously to the clock.
- R2: A bus write with `addr[3]`=0 targets a frequency buffer. `addr[2]`=0 selects buffer A and `addr[2]`=1 selects buffer B. `addr[1:0]` selects the byte lane, where lane n holds bits 8n+7:8n, so lane 00 is the least significant byte.
- R3: In a cycle where `freq_load` is high, `freq_word` takes buffer A when `freq_sel`=1 and buffer B when `freq_sel`=0. In any other cycle `freq_word` holds its value.
- R4: A bus write with `addr[3]`=1 and `addr[0]`=0 places `data[7:4]` in bits 3:0 of a phase buffer. Bits 11:4 of that buffer are left unchanged.
- R5: A bus write with `addr[3]`=1 and `addr[0]`=1 places `data[7:0]` in bits 11:4 of a phase buffer. `addr[1]`=0 targets the sine buffer and `addr[1]`=1 targets the cosine buffer. `addr[2]` is ignored.
- R6: A write that is detected while `cs_n` is high changes no buffer.
- R7: Exactly one write is made per rising edge of `wr_strobe`. The write takes place two clock edges after the synchroniser first samples the strobe high. Data that changes while the strobe stays high is not captured.
- R8: While `phase_src`=0, `sin_phase` and `cos_phase` both equal `{data, addr}` one clock after it is sampled. This holds whatever the state of `wr_strobe` and `cs_n`.
- R9: Writing one byte leaves every other byte of every buffer unchanged, so lanes may be written in any order.
- R10: While `phase_src`=1, `sin_phase` follows the sine buffer and `cos_phase` follows the cosine buffer, each with one clock of delay. The two channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Write strobe; a write is made on each rising edge |
| cs_n | input | 1 | Active-low chip select for bus writes |
| addr | input | 4 | Register and lane select; low phase bits in direct mode |
| data | input | 8 | Write data; high phase bits in direct mode |
| freq_sel | input | 1 | 1 selects buffer A, 0 selects buffer B for a load |
| freq_load | input | 1 | Frequency-load request, one cycle per load |
| phase_src | input | 1 | 1 selects the buffered phase, 0 selects the direct pins |
| freq_word | output | 32 | Loaded frequency increment |
| sin_phase | output | 12 | Sine channel phase offset |
| cos_phase | output | 12 | Cosine channel phase offset |

## Verification
The buffers cannot be seen directly. Frequency contents only show at the ports after a load, and phase contents only show in buffered mode. Each write is therefore followed by a load, or by a read in buffered mode, before the result is compared against a model kept in the bench.

The hardest case to bring about is a strobe that stays high while the data under it changes. The bench holds the strobe high across several clocks, swaps the data partway through, and then confirms that only the first value reached the buffer. Rejected writes are exposed the same way: after a write with the chip select high, the bench reloads the buffer it targeted and checks that nothing changed.

// File: rtl/nco_wr_port.sv
module nco_wr_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_strobe,
  input  logic        cs_n,
  input  logic [3:0]  addr,
  input  logic [7:0]  data,
  input  logic        freq_sel,
  input  logic        freq_load,
  input  logic        phase_src,
  output logic [31:0] freq_word,
  output logic [11:0] sin_phase,
  output logic [11:0] cos_phase
);

  logic [2:0]  stb_q;
  logic        wr_edge;
  logic        wr_go;
  logic [31:0] freq_a, freq_b;
  logic [11:0] sin_buf, cos_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_q <= '0;
    else        stb_q <= {stb_q[1:0], wr_strobe};

  assign wr_edge = stb_q[1] & ~stb_q[2];
  assign wr_go   = wr_edge & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_a  <= '0;
      freq_b  <= '0;
      sin_buf <= '0;
      cos_buf <= '0;
    end else if (wr_go) begin
      if (!addr[3]) begin
        if (!addr[2]) freq_a[{addr[1:0], 3'b000} +: 8] <= data;
        else          freq_b[{addr[1:0], 3'b000} +: 8] <= data;
      end else if (!addr[1]) begin
        if (addr[0]) sin_buf[11:4] <= data;
        else         sin_buf[3:0]  <= data[7:4];
      end else begin
        if (addr[0]) cos_buf[11:4] <= data;
        else         cos_buf[3:0]  <= data[7:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         freq_word <= '0;
    else if (freq_load) freq_word <= freq_sel ? freq_a : freq_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_phase <= '0;
      cos_phase <= '0;
    end else if (!phase_src) begin
      sin_phase <= {data, addr};
      cos_phase <= {data, addr};
    end else begin
      sin_phase <= sin_buf;
      cos_phase <= cos_buf;
    end
  end

  p_hold_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_load |=> $stable(freq_word));

  p_cs_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_edge && cs_n) |=> ($stable(freq_a) && $stable(freq_b) && $stable(sin_buf) && $stable(cos_buf)));

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> !wr_edge);

  p_freq_lane_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !addr[3]) |=> ($stable(sin_buf) && $stable(cos_buf)));

  p_phase_no_freq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && addr[3]) |=> ($stable(freq_a) && $stable(freq_b)));

  p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !addr[3]) |=> ($countones(freq_a ^ $past(freq_a)) <= 8 && $countones(freq_b ^ $past(freq_b)) <= 8));

  p_direct_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_src |=> (sin_phase == cos_phase));

endmodule

// File: tb/sim_nco_wr_port.sv
module sim_nco_wr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  data = '0;
  logic        freq_sel = 1'b0;
  logic        freq_load = 1'b0;
  logic        phase_src = 1'b1;
  logic [31:0] freq_word;
  logic [11:0] sin_phase, cos_phase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_a = '0, exp_b = '0;
  logic [11:0] exp_sin = '0, exp_cos = '0;

  always #10 clk = ~clk;

  nco_wr_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n),
    .addr(addr), .data(data), .freq_sel(freq_sel), .freq_load(freq_load),
    .phase_src(phase_src), .freq_word(freq_word),
    .sin_phase(sin_phase), .cos_phase(cos_phase)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    if (!a[3]) begin
      if (!a[2]) exp_a[{a[1:0], 3'b000} +: 8] = d;
      else       exp_b[{a[1:0], 3'b000} +: 8] = d;
    end else if (!a[1]) begin
      if (a[0]) exp_sin[11:4] = d; else exp_sin[3:0] = d[7:4];
    end else begin
      if (a[0]) exp_cos[11:4] = d; else exp_cos[3:0] = d[7:4];
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    addr = a; data = d; cs_n = cs; wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    if (!cs) model_write(a, d);
  endtask

  task automatic do_load(input logic sel);
    @(negedge clk);
    freq_sel = sel; freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 freq_word", freq_word, 32'h0);
    check("R1 sin_phase", {20'h0, sin_phase}, 32'h0);
    check("R1 cos_phase", {20'h0, cos_phase}, 32'h0);
  endtask

  task automatic t_freq_lanes;
    bus_write(4'b0010, 8'h33, 1'b0);
    bus_write(4'b0000, 8'h11, 1'b0);
    bus_write(4'b0011, 8'h44, 1'b0);
    bus_write(4'b0001, 8'h22, 1'b0);
    for (int i = 0; i < 4; i++) bus_write({2'b01, i[1:0]}, 8'hA0 + 8'(i), 1'b0);
    do_load(1'b1);
    check("R2 R9 buffer A lanes", freq_word, exp_a);
    check("R2 A value", freq_word, 32'h44332211);
    do_load(1'b0);
    check("R3 buffer B selected", freq_word, 32'hA3A2A1A0);
  endtask

  task automatic t_partial_and_hold;
    bus_write(4'b0001, 8'h5E, 1'b0);
    do_load(1'b1);
    check("R9 single lane update", freq_word, 32'h44335E11);
    @(negedge clk);
    freq_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 hold without load", freq_word, 32'h44335E11);
  endtask

  task automatic t_cs_block;
    bus_write(4'b0000, 8'hFF, 1'b1);
    bus_write(4'b1001, 8'hFF, 1'b1);
    do_load(1'b1);
    check("R6 cs_n high blocks freq write", freq_word, exp_a);
    check("R6 cs_n high blocks phase write", {20'h0, sin_phase}, {20'h0, exp_sin});
  endtask

  task automatic t_phase_bufs;
    phase_src = 1'b1;
    bus_write(4'b1001, 8'hC7, 1'b0);
    bus_write(4'b1000, 8'h5C, 1'b0);
    bus_write(4'b1111, 8'h3B, 1'b0);
    bus_write(4'b1110, 8'h9F, 1'b0);
    check("R4 R5 sine buffer", {20'h0, sin_phase}, 32'hC75);
    check("R5 R10 cosine buffer addr2 ignored", {20'h0, cos_phase}, 32'h3B9);
    bus_write(4'b1000, 8'hE0, 1'b0);
    check("R4 nibble keeps high byte", {20'h0, sin_phase}, 32'hC7E);
    check("R10 cosine untouched", {20'h0, cos_phase}, 32'h3B9);
    do_load(1'b1);
    check("R5 phase write spares freq", freq_word, exp_a);
  endtask

  task automatic t_held_strobe;
    @(negedge clk);
    addr = 4'b1011; data = 8'h12; cs_n = 1'b0; wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    data = 8'h87;
    repeat (4) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    exp_cos[11:4] = 8'h12;
    check("R7 one write per strobe edge", {20'h0, cos_phase}, {20'h0, exp_cos});
  endtask

  task automatic t_direct;
    @(negedge clk);
    phase_src = 1'b0; addr = 4'h5; data = 8'hA3; cs_n = 1'b1; wr_strobe = 1'b0;
    @(negedge clk);
    check("R8 direct sine", {20'h0, sin_phase}, 32'hA35);
    check("R8 direct cosine", {20'h0, cos_phase}, 32'hA35);
    addr = 4'hC; data = 8'h0F; wr_strobe = 1'b1;
    @(negedge clk);
    check("R8 direct with strobe high", {20'h0, sin_phase}, 32'h0FC);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    phase_src = 1'b1;
    @(negedge clk);
    check("R10 back to sine buffer", {20'h0, sin_phase}, {20'h0, exp_sin});
    check("R10 back to cosine buffer", {20'h0, cos_phase}, {20'h0, exp_cos});
  endtask

  task automatic t_async_reset;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async clear freq", freq_word, 32'h0);
    check("R1 async clear sine", {20'h0, sin_phase}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_a = '0; exp_b = '0; exp_sin = '0; exp_cos = '0;
    do_load(1'b1);
    check("R1 buffer A cleared", freq_word, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_freq_lanes();
    t_partial_and_hold();
    t_cs_block();
    t_phase_bufs();
    t_held_strobe();
    t_direct();
    t_async_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule